// File: doc/BRIEF.md
# Fully Associative Address Translator

This block turns a 32-bit virtual byte address into a 28-bit physical byte address over 4 KB pages. The low 12 bits pass through unchanged. The upper 20 bits, the virtual page number, are compared against every resident translation at once. A match returns the 16-bit frame number from the matching slot. A resident translation also carries writable and dirty flags, and each slot has a valid flag.

When no slot matches, the block reads one page-table entry itself. It adds the virtual page number to a table base input and issues a single read on its memory port. When the read returns, it either installs the entry and answers, or raises a page fault. A store to a page without write permission gets a protection fault instead of an address. A one-cycle flush input empties every slot. When all slots are in use, a rotating pointer chooses the slot to overwrite.

Top module: `tlb_xlate`

## Requirements
- R1: On a fault-free response, resp_paddr[11:0] equals the request's vaddr[11:0] and resp_paddr[27:12] equals the frame number of the translation used.
- R2: A request whose page is resident produces resp_valid with resp_hit=1 exactly one cycle after acceptance, and mem_req_valid stays low.
- R3: A request whose page is not resident raises mem_req_valid in the cycle after acceptance, with mem_req_addr = ptbr + zero-extended vaddr[31:12]. mem_req_valid and mem_req_addr hold until mem_rsp_valid, provided ptbr is held stable.
- R4: A page-table entry uses bits [15:0] for the frame, bit 16 for valid, bit 17 for writable and bit 18 for dirty. When a fetched entry has bit 16 set, resp_valid with resp_hit=0 follows one cycle after mem_rsp_valid, and the entry is installed so the next access to that page hits.
- R5: A fetched entry with bit 16 clear gives resp_page_fault=1 and resp_paddr=0. The entry is not installed, so the next access to that page walks again.
- R6: A store (req_store=1) to a page whose writable bit is clear gives resp_prot_fault=1 and resp_paddr=0, on both the hit path and the walk path. Loads from that page translate normally, and a store to a writable page completes.
- R7: Free slots are filled lowest index first. With every slot valid, a new install overwrites the slot at a rotating pointer, which starts at slot 0 after reset and steps by one, wrapping, after each such overwrite.
- R8: A one-cycle pulse on inv_all empties every slot, so every later access walks again.
- R9: req_ready is low during a walk, and req_valid is ignored while req_ready is low. No extra walk or response follows from it.
- R10: resp_dirty reports the translation's dirty flag after the access. The flag is set by the fetched entry's bit 18 or by a permitted store, and it stays set for later hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 32 | Virtual byte address |
| req_store | input | 1 | Request is a store |
| ptbr | input | 32 | Page-table base address |
| inv_all | input | 1 | Empty all translation slots |
| mem_req_valid | output | 1 | Page-table read outstanding |
| mem_req_addr | output | 32 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table read data is present |
| mem_rsp_data | input | 19 | Page-table entry |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_paddr | output | 28 | Physical byte address, zero on a fault |
| resp_hit | output | 1 | Translation came from a resident slot |
| resp_dirty | output | 1 | Dirty flag of the translation |
| resp_page_fault | output | 1 | Fetched entry was not valid |
| resp_prot_fault | output | 1 | Store to a non-writable page |

## Verification
The bench builds the block with its default of eight slots. This makes filling every slot and wrapping the rotating pointer reachable in about a dozen accesses, so the replacement order can be observed through hit and miss outcomes alone. The table base is set to 0x0003FFF0, so that adding the page number carries across the upper address bits. The bench's page-table model derives the validity and write permission of each entry from the page number. This places page faults, protection faults and dirty entries at known pages.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 28;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int PTE_V_BIT = PFN_W;
  localparam int PTE_W_BIT = PFN_W + 1;
  localparam int PTE_D_BIT = PFN_W + 2;
  localparam int PTE_W     = PFN_W + 3;

  typedef struct packed {
    logic             valid;
    logic             writable;
    logic             dirty;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
  } slot_t;

  function automatic logic [VA_W-1:0] pte_addr(input logic [VA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + VA_W'(vpn);
  endfunction

  function automatic logic [PA_W-1:0] join_paddr(input logic [PFN_W-1:0] pfn,
                                                 input logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  function automatic slot_t pte_to_slot(input logic [VPN_W-1:0] vpn,
                                        input logic [PTE_W-1:0] pte);
    slot_t s;
    s.valid    = pte[PTE_V_BIT];
    s.writable = pte[PTE_W_BIT];
    s.dirty    = pte[PTE_D_BIT];
    s.vpn      = vpn;
    s.pfn      = pte[PFN_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic               lk_writable,
  output logic               lk_dirty,
  input  logic               inv_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  slot_t              wr_slot,
  input  logic               dirty_en,
  input  logic [IDX_W-1:0]   dirty_idx,
  output logic [ENTRIES-1:0] valid_vec
);
  slot_t              ent_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g]     = ent_q[g].valid && (ent_q[g].vpn == lk_vpn);
    assign valid_vec[g] = ent_q[g].valid;
  end

  always_comb begin
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) lk_idx = IDX_W'(i);
  end

  assign lk_hit      = |match;
  assign lk_pfn      = ent_q[lk_idx].pfn;
  assign lk_writable = ent_q[lk_idx].writable;
  assign lk_dirty    = ent_q[lk_idx].dirty;

  always_ff @(posedge clk) begin
    if (!rst_n || inv_all) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else begin
      if (dirty_en) ent_q[dirty_idx].dirty <= 1'b1;
      if (wr_en)    ent_q[wr_idx]          <= wr_slot;
    end
  end

  // R2: installs happen only after a miss, so a page is never resident twice
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx
);
  logic             full;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;

  assign full = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  assign victim_idx = full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (take && full)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  a_r7_free_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic [VA_W-1:0]  ptbr,
  input  logic             inv_all,
  output logic             mem_req_valid,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_hit,
  output logic             resp_dirty,
  output logic             resp_page_fault,
  output logic             resp_prot_fault
);
  typedef enum logic {ST_IDLE, ST_WALK} state_t;
  state_t           st_q;
  logic [VA_W-1:0]  vaddr_q;
  logic             store_q;

  logic             lk_hit, lk_writable, lk_dirty;
  logic [IDX_W-1:0] lk_idx, victim_idx;
  logic [PFN_W-1:0] lk_pfn;
  logic [ENTRIES-1:0] valid_vec;

  // named events
  logic  accept_ev, hit_ev, miss_ev, fill_ev, install_ev, dirty_ev;
  logic  hit_prot, fill_ok, fill_prot;
  slot_t fill_slot;

  assign req_ready  = (st_q == ST_IDLE);
  assign accept_ev  = req_valid && req_ready;
  assign hit_ev     = accept_ev && lk_hit;
  assign miss_ev    = accept_ev && !lk_hit;
  assign fill_ev    = (st_q == ST_WALK) && mem_rsp_valid;
  assign fill_slot  = pte_to_slot(vaddr_q[VA_W-1:OFF_W], mem_rsp_data);
  assign fill_ok    = fill_slot.valid;
  assign fill_prot  = fill_ok && store_q && !fill_slot.writable;
  assign install_ev = fill_ev && fill_ok && !inv_all;
  assign hit_prot   = req_store && !lk_writable;
  assign dirty_ev   = hit_ev && req_store && lk_writable && !inv_all;

  assign mem_req_valid = (st_q == ST_WALK);
  assign mem_req_addr  = pte_addr(ptbr, vaddr_q[VA_W-1:OFF_W]);

  tlb_cam #(.ENTRIES(ENTRIES)) cam_i (
    .clk, .rst_n,
    .lk_vpn(req_vaddr[VA_W-1:OFF_W]), .lk_hit, .lk_idx, .lk_pfn, .lk_writable, .lk_dirty,
    .inv_all,
    .wr_en(install_ev), .wr_idx(victim_idx),
    .wr_slot(fill_prot ? fill_slot : '{valid: fill_slot.valid, writable: fill_slot.writable,
                                       dirty: fill_slot.dirty | store_q, vpn: fill_slot.vpn,
                                       pfn: fill_slot.pfn}),
    .dirty_en(dirty_ev), .dirty_idx(lk_idx),
    .valid_vec
  );

  tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk, .rst_n, .valid_vec, .take(install_ev), .victim_idx
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      vaddr_q <= '0;
      store_q <= 1'b0;
    end else begin
      if (accept_ev) begin
        vaddr_q <= req_vaddr;
        store_q <= req_store;
      end
      if (miss_ev)      st_q <= ST_WALK;
      else if (fill_ev) st_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_paddr      <= '0;
      resp_hit        <= 1'b0;
      resp_dirty      <= 1'b0;
      resp_page_fault <= 1'b0;
      resp_prot_fault <= 1'b0;
    end else begin
      resp_valid <= hit_ev || fill_ev;
      if (hit_ev) begin
        resp_hit        <= 1'b1;
        resp_page_fault <= 1'b0;
        resp_prot_fault <= hit_prot;
        resp_dirty      <= lk_dirty || (req_store && lk_writable);
        resp_paddr      <= hit_prot ? '0 : join_paddr(lk_pfn, req_vaddr[OFF_W-1:0]);
      end else if (fill_ev) begin
        resp_hit        <= 1'b0;
        resp_page_fault <= !fill_ok;
        resp_prot_fault <= fill_prot;
        resp_dirty      <= fill_ok && (fill_slot.dirty || (store_q && !fill_prot));
        resp_paddr      <= (fill_ok && !fill_prot) ?
                           join_paddr(fill_slot.pfn, vaddr_q[OFF_W-1:0]) : '0;
      end
    end
  end

  a_r1_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_page_fault && !resp_prot_fault
      |-> resp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);
  a_r3_walk_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(req_valid));
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && $past(mem_req_valid) && $stable(ptbr) |-> $stable(mem_req_addr));
  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_page_fault || resp_prot_fault) |-> resp_paddr == '0);
  a_r5_single_fault_kind: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_page_fault && resp_prot_fault));
  a_r9_busy_during_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, inv_all = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] ptbr = 32'h0003_FFF0;
  logic        mem_rsp_valid = 1'b0;
  logic [18:0] mem_rsp_data = '0;
  logic        req_ready, mem_req_valid, resp_valid, resp_hit, resp_dirty;
  logic        resp_page_fault, resp_prot_fault;
  logic [31:0] mem_req_addr;
  logic [27:0] resp_paddr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_xlate dut_i (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // bench page table: frame = vpn ^ 5A3C, valid unless low nibble is F,
  // writable for even pages, dirty preset for pages whose bit 1 is set
  function automatic logic [18:0] pte_of(input logic [19:0] vpn);
    return {vpn[1], ~vpn[0], vpn[3:0] != 4'hF, vpn[15:0] ^ 16'h5A3C};
  endfunction

  // one access; exp_hit chooses the path, poke drives a stray request mid-walk
  task automatic access(input logic [31:0] va, input bit st, input bit exp_hit,
                        input bit exp_dirty, input bit poke, input string rq);
    logic [18:0] pte = pte_of(va[31:12]);
    bit pf   = !exp_hit && !pte[16];
    bit prot = !pf && st && !pte[17];
    logic [27:0] pa = (pf || prot) ? 28'h0 : {pte[15:0], va[11:0]};
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk(resp_valid && resp_hit && !mem_req_valid, {rq, " R2"},
          {resp_valid, resp_hit, mem_req_valid}, 3'b110);
    end else begin
      chk(mem_req_valid && mem_req_addr == ptbr + {12'h0, va[31:12]}, {rq, " R3"},
          {mem_req_valid, mem_req_addr}, {1'b1, ptbr + {12'h0, va[31:12]}});
      if (poke) begin
        req_valid = 1'b1; req_vaddr = 32'h7777_7000; req_store = 1'b0;
      end
      @(negedge clk);
      chk(!req_ready, "R9", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_req_valid && !resp_valid && mem_req_addr == ptbr + {12'h0, va[31:12]},
          {rq, " R3 hold"}, mem_req_addr, ptbr + {12'h0, va[31:12]});
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk(resp_valid && !resp_hit, {rq, " R4"}, {resp_valid, resp_hit}, 2'b10);
    end
    chk(resp_paddr == pa, {rq, " R1"}, resp_paddr, pa);
    chk(resp_page_fault == pf, {rq, " R5"}, resp_page_fault, pf);
    chk(resp_prot_fault == prot, {rq, " R6"}, resp_prot_fault, prot);
    if (!pf && !prot) chk(resp_dirty == exp_dirty, {rq, " R10"}, resp_dirty, exp_dirty);
    @(negedge clk);
    chk(!resp_valid && !mem_req_valid, {rq, " R9 no extra"}, {resp_valid, mem_req_valid}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!resp_valid && !mem_req_valid && req_ready, "reset", {resp_valid, mem_req_valid, req_ready}, 3'b001);
  endtask

  task automatic t_hit_miss();
    access(32'h1234_4678, 0, 0, 0, 0, "R4 first");
    access(32'h1234_4ABC, 0, 1, 0, 0, "R2 again");
    access(32'h0004_0FFF, 0, 0, 0, 1, "R9 poke");
    access(32'h0004_0001, 0, 1, 0, 0, "R1 hit");
  endtask

  task automatic t_page_fault();
    access(32'h0000_F123, 0, 0, 0, 0, "R5 first");
    access(32'h0000_F123, 0, 0, 0, 0, "R5 not kept");
  endtask

  task automatic t_protect();
    access(32'h0001_1004, 1, 0, 0, 0, "R6 walk store");
    access(32'h0001_1008, 1, 1, 0, 0, "R6 hit store");
    access(32'h0001_100C, 0, 1, 0, 0, "R6 load ok");
    access(32'h0001_0010, 1, 0, 1, 0, "R10 store walk");
    access(32'h0001_4010, 0, 0, 0, 0, "R10 clean");
    access(32'h0001_4020, 1, 1, 1, 0, "R10 store hit");
    access(32'h0001_4030, 0, 1, 1, 0, "R10 sticky");
    access(32'h0001_2000, 0, 0, 1, 0, "R10 preset");
  endtask

  task automatic t_flush();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    access(32'h1234_4000, 0, 0, 0, 0, "R8 flushed a");
    access(32'h0001_4000, 0, 0, 0, 0, "R8 flushed b");
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
  endtask

  task automatic t_round_robin();
    for (int i = 0; i < 8; i++)
      access({20'h00100 + 20'(i*4), 12'h000}, 0, 0, 0, 0, "R7 fill");
    access(32'h0012_0000, 0, 0, 0, 0, "R7 evict slot0");
    access(32'h0010_4000, 0, 1, 0, 0, "R7 slot1 kept");
    access(32'h0010_0000, 0, 0, 0, 0, "R7 evict slot1");
    access(32'h0010_4000, 0, 0, 0, 0, "R7 evict slot2");
    access(32'h0010_C000, 0, 1, 0, 0, "R7 slot3 kept");
    access(32'h0010_8000, 0, 0, 0, 0, "R7 evict slot3");
    access(32'h0012_0000, 0, 1, 0, 0, "R7 new kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit_miss();
    t_page_fault();
    t_protect();
    t_flush();
    t_round_robin();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(150_000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule